// File: doc/BRIEF.md
# Dual-Limit Programmable Interval Timer

A single 16-bit timer channel. A count register advances on timer events. Each time the count would reach the active limit it returns to zero instead, and that is a terminal count. Events come from one of two sources. The first is an internal tick that fires once every fourth clock. The second is a synchronized rising edge on the `tmr_in` pin. The same pin can also act as a level gate or as a restart trigger.

The channel holds two limit registers, A and B. In single-limit mode only limit A is compared, and `tmr_out` drops low for one clock after each terminal count. In alternate mode the channel swaps limits at every terminal count, and `tmr_out` shows which limit is active, so software sets the duty cycle through the two limit values.

At a terminal count the channel can halt by clearing its enable, or it can keep running. It can also pulse an interrupt request. Software reaches the control word, the count and both limits through a small register port. Every access on that port takes one wait state.

Top module: `dual_limit_timer`

## Requirements
- R1: The register port uses address 0 for the control word, 1 for the count, 2 for limit A and 3 for limit B, all 16 bits wide. Each register reads back what was written. The count may be written at any time, including while the channel runs, and the written value takes precedence over counting in that cycle.
- R2: When count+1 equals the active limit, the count becomes zero in that same clock, so it never holds the limit. A limit of 0 gives a period of 65536 events.
- R3: With alternate mode off, `tmr_out` is high except for exactly one clock, the clock after the edge that produced a terminal count.
- R4: With alternate mode on, each terminal count swaps the active limit between A and B. `tmr_out` is high while A is active and low while B is active. Control bit 12 is read-only and reads 1 while B is the active limit.
- R5: The channel is serviced on one clock in every four. With the internal source, the count advances by exactly one per serviced clock while enabled.
- R6: Control word layout: bit 15 enable, bit 14 enable-write strobe (reads 0), bit 13 interrupt enable, bit 12 active-limit flag, bit 5 terminal-count flag, bit 4 retrigger, bit 3 external source, bit 2 prescale (stored only), bit 1 alternate, bit 0 continuous. Bits 11 to 6 read 0. A control write changes bit 15 only when bit 14 is 1 in that same write.
- R7: With continuous=0, a terminal count clears the enable and the count stops. With continuous=1, counting goes on.
- R8: The terminal-count flag sets at every terminal count. Writing 0 to it clears it. Writing 1 leaves it unchanged.
- R9: `bus_ready` is low in the first clock of an access and high in the second. A write commits on the clock edge that ends the ready cycle, and read data is valid while `bus_ready` is high.
- R10: With interrupt enable set, `irq_req` pulses for one clock, in the same clock that `tmr_out` is low for that terminal count. With interrupt enable clear, it stays low.
- R11: With the external source selected, each rising edge of `tmr_in`, after a two-flop synchronizer, is one count event. An edge on `tmr_in` changes `tmr_out` within 3 to 6 clocks.
- R12: With the internal source and retrigger=0, `tmr_in` is a level gate: ticks count only while it is high.
- R13: With the internal source and retrigger=1, ticks count whatever the level of `tmr_in`. A rising edge on `tmr_in` resets the count to zero instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while ready |
| bus_ready | output | 1 | Access completes this clock |
| tmr_in | input | 1 | External event, gate or trigger input |
| tmr_out | output | 1 | Timer output pin |
| irq_req | output | 1 | One-clock interrupt request pulse |

## Verification
Each result has a fixed latency, and the bench samples at it. A write commits two edges after `bus_sel` is raised, and read data is sampled in the ready clock. `tmr_out` and `irq_req` change in the clock after the terminal-count edge, and a pin edge needs 3 to 6 clocks to reach the output. To keep the unknown service phase out of count checks, the bench spaces the commit of the enable write and the commit of the disable write exactly 4N edges apart. Any such window holds exactly N serviced clocks, so the expected count is exact. Latency checks count clocks at the falling edge and compare against the 3..6 window.

// File: rtl/dlt_pkg.sv
package dlt_pkg;

   localparam int DLT_DATA_W = 16;

   localparam int B_EN   = 15;
   localparam int B_STRB = 14;
   localparam int B_INT  = 13;
   localparam int B_RIU  = 12;
   localparam int B_MC   = 5;
   localparam int B_RTG  = 4;
   localparam int B_EXT  = 3;
   localparam int B_PRE  = 2;
   localparam int B_ALT  = 1;
   localparam int B_CONT = 0;

   typedef enum logic [1:0] {
      A_CTL  = 2'd0,
      A_CNT  = 2'd1,
      A_LIMA = 2'd2,
      A_LIMB = 2'd3
   } dlt_addr_e;

   typedef struct packed {
      logic en;
      logic int_en;
      logic riu;
      logic mc;
      logic rtg;
      logic ext;
      logic pre;
      logic alt;
      logic cont;
   } dlt_ctl_t;

   function automatic logic [DLT_DATA_W-1:0] pack_ctl(input dlt_ctl_t c);
      logic [DLT_DATA_W-1:0] w;
      w         = '0;
      w[B_EN]   = c.en;
      w[B_INT]  = c.int_en;
      w[B_RIU]  = c.riu;
      w[B_MC]   = c.mc;
      w[B_RTG]  = c.rtg;
      w[B_EXT]  = c.ext;
      w[B_PRE]  = c.pre;
      w[B_ALT]  = c.alt;
      w[B_CONT] = c.cont;
      return w;
   endfunction

endpackage

// File: rtl/dlt_slot_gen.sv
module dlt_slot_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot
);
   localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;

   generate
      if (DIV == 2) begin : g_toggle
         logic ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph <= 1'b0;
            else        ph <= ~ph;
         end
         assign slot = ph;
      end else begin : g_count
         logic [PH_W-1:0] ph;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph <= '0;
            else        ph <= ph + 1'b1;
         end
         assign slot = (ph == PH_W'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/dlt_sync_edge.sv
module dlt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic consume,
   output logic level,
   output logic edge_evt
);
   logic [STAGES-1:0] chain;
   logic              prev;
   logic              pend;
   logic              edge_now;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= pin;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin};
         end
      end
   endgenerate

   assign level    = chain[STAGES-1];
   assign edge_now = level & ~prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev <= 1'b0;
         pend <= 1'b0;
      end else begin
         prev <= level;
         if (consume)       pend <= 1'b0;
         else if (edge_now) pend <= 1'b1;
      end
   end

   assign edge_evt = pend | edge_now;
endmodule

// File: rtl/dlt_bus_if.sv
module dlt_bus_if
   import dlt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic [1:0] bus_addr,
   output logic       bus_ready,
   output logic       wr_ctl,
   output logic       wr_cnt,
   output logic       wr_lima,
   output logic       wr_limb
);
   logic       wait_done;
   logic       commit;
   dlt_addr_e  sel_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         wait_done <= 1'b0;
      else if (wait_done) wait_done <= 1'b0;
      else                wait_done <= bus_sel;
   end

   assign bus_ready = wait_done & bus_sel;
   assign commit    = bus_ready & bus_wr;
   assign sel_reg   = dlt_addr_e'(bus_addr);

   assign wr_ctl  = commit && (sel_reg == A_CTL);
   assign wr_cnt  = commit && (sel_reg == A_CNT);
   assign wr_lima = commit && (sel_reg == A_LIMA);
   assign wr_limb = commit && (sel_reg == A_LIMB);
endmodule

// File: rtl/dlt_core.sv
module dlt_core
   import dlt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot,
   input  logic              evt_edge,
   input  logic              evt_level,
   input  logic              wr_ctl,
   input  logic              wr_cnt,
   input  logic              wr_lima,
   input  logic              wr_limb,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  lim_a,
   output logic [CNT_W-1:0]  lim_b,
   output dlt_ctl_t          ctl,
   output logic              tc_q,
   output logic              irq_q
);
   logic [CNT_W-1:0] lim_act;
   logic [CNT_W-1:0] cnt_inc;
   logic [CNT_W-1:0] cnt_nxt;
   logic             restart;
   logic             step;
   logic             hit;
   logic             en_wr;
   dlt_ctl_t         ctl_nxt;

   assign lim_act = (ctl.alt && ctl.riu) ? lim_b : lim_a;
   assign restart = slot && ctl.en && !ctl.ext && ctl.rtg && evt_edge;
   assign step    = slot && ctl.en && !restart &&
                    (ctl.ext ? evt_edge : (ctl.rtg | evt_level));
   assign cnt_inc = count + 1'b1;
   assign hit     = step && (cnt_inc == lim_act);
   assign en_wr   = wr_ctl && wdata[B_STRB];

   always_comb begin
      if (wr_cnt)                cnt_nxt = wdata[CNT_W-1:0];
      else if (restart || hit)   cnt_nxt = '0;
      else if (step)             cnt_nxt = cnt_inc;
      else                       cnt_nxt = count;
   end

   always_comb begin
      ctl_nxt = ctl;
      if (wr_ctl) begin
         ctl_nxt.int_en = wdata[B_INT];
         ctl_nxt.rtg    = wdata[B_RTG];
         ctl_nxt.ext    = wdata[B_EXT];
         ctl_nxt.pre    = wdata[B_PRE];
         ctl_nxt.alt    = wdata[B_ALT];
         ctl_nxt.cont   = wdata[B_CONT];
         ctl_nxt.mc     = ctl.mc & wdata[B_MC];
         if (en_wr) ctl_nxt.en = wdata[B_EN];
      end
      if (hit) begin
         ctl_nxt.mc  = 1'b1;
         ctl_nxt.riu = ctl.alt ? ~ctl.riu : 1'b0;
         if (!ctl.cont && !en_wr) ctl_nxt.en = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         lim_a <= '0;
         lim_b <= '0;
         ctl   <= '0;
         tc_q  <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         count <= cnt_nxt;
         if (wr_lima) lim_a <= wdata[CNT_W-1:0];
         if (wr_limb) lim_b <= wdata[CNT_W-1:0];
         ctl   <= ctl_nxt;
         tc_q  <= hit;
         irq_q <= hit && ctl.int_en;
      end
   end
endmodule

// File: rtl/dual_limit_timer.sv
module dual_limit_timer
   import dlt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SERVICE_DIV = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_sel,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [15:0] bus_wdata,
   output logic [15:0] bus_rdata,
   output logic        bus_ready,
   input  logic        tmr_in,
   output logic        tmr_out,
   output logic        irq_req
);
   localparam int DATA_W = DLT_DATA_W;

   generate
      if (CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("CNT_W must lie in 4..16");
      end
      if (SERVICE_DIV < 2 || (SERVICE_DIV & (SERVICE_DIV - 1)) != 0) begin : g_bad_div
         $error("SERVICE_DIV must be a power of two, at least 2");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic             slot;
   logic             evt_edge;
   logic             evt_level;
   logic             wr_ctl, wr_cnt, wr_lima, wr_limb;
   logic [CNT_W-1:0] count, lim_a, lim_b;
   dlt_ctl_t         ctl;
   logic             tc_q;
   logic             irq_q;

   dlt_slot_gen #(.DIV(SERVICE_DIV)) u_slot (
      .clk  (clk),
      .rst_n(rst_n),
      .slot (slot)
   );

   dlt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (tmr_in),
      .consume (slot),
      .level   (evt_level),
      .edge_evt(evt_edge)
   );

   dlt_bus_if u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_ready(bus_ready),
      .wr_ctl   (wr_ctl),
      .wr_cnt   (wr_cnt),
      .wr_lima  (wr_lima),
      .wr_limb  (wr_limb)
   );

   dlt_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot     (slot),
      .evt_edge (evt_edge),
      .evt_level(evt_level),
      .wr_ctl   (wr_ctl),
      .wr_cnt   (wr_cnt),
      .wr_lima  (wr_lima),
      .wr_limb  (wr_limb),
      .wdata    (bus_wdata),
      .count    (count),
      .lim_a    (lim_a),
      .lim_b    (lim_b),
      .ctl      (ctl),
      .tc_q     (tc_q),
      .irq_q    (irq_q)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_ready && !bus_wr) begin
         case (dlt_addr_e'(bus_addr))
            A_CTL:   bus_rdata = pack_ctl(ctl);
            A_CNT:   bus_rdata = DATA_W'(count);
            A_LIMA:  bus_rdata = DATA_W'(lim_a);
            default: bus_rdata = DATA_W'(lim_b);
         endcase
      end
   end

   assign tmr_out = ctl.alt ? ~ctl.riu : ~tc_q;
   assign irq_req = irq_q;

endmodule

// File: rtl/dlt_checker.sv
module dlt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_ready,
   input logic             tmr_out,
   input logic             irq_req,
   input logic [CNT_W-1:0] count,
   input logic             tc_q,
   input logic             wr_cnt,
   input logic             wr_ctl,
   input logic             slot,
   input logic             alt,
   input logic             riu,
   input logic             mc,
   input logic             en,
   input logic             cont
);
   assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q && !$past(wr_cnt)) |-> (count == '0));

   assert_pulse_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!alt && !tmr_out) |=> (tmr_out || alt));

   assert_riu_moves_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (riu != $past(riu)) |-> tc_q);

   assert_riu_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q && $past(alt)) |-> (riu != $past(riu)));

   assert_slot_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |-> ($past(slot) || $past(wr_cnt)));

   assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q && !$past(cont) && !$past(wr_ctl)) |-> !en);

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc_q |-> mc);

   assert_wait_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_sel) |-> !bus_ready);

   assert_ready_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ready |=> !bus_ready);

   assert_irq_tc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> tc_q);
endmodule

bind dual_limit_timer dlt_checker #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_ready(bus_ready),
   .tmr_out  (tmr_out),
   .irq_req  (irq_req),
   .count    (count),
   .tc_q     (tc_q),
   .wr_cnt   (wr_cnt),
   .wr_ctl   (wr_ctl),
   .slot     (slot),
   .alt      (ctl.alt),
   .riu      (ctl.riu),
   .mc       (ctl.mc),
   .en       (ctl.en),
   .cont     (ctl.cont)
);

// File: tb/dual_limit_timer_tb.sv
module dual_limit_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        bus_ready;
   logic        tmr_in = 1'b0;
   logic        tmr_out;
   logic        irq_req;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   bit mon_on = 1'b0;
   int low_cnt = 0;
   int irq_cnt = 0;
   int irq_mis = 0;

   always #2 clk = ~clk;

   dual_limit_timer u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .bus_ready(bus_ready),
      .tmr_in   (tmr_in),
      .tmr_out  (tmr_out),
      .irq_req  (irq_req)
   );

   localparam logic [1:0] AD_CTL = 2'd0, AD_CNT = 2'd1, AD_LA = 2'd2, AD_LB = 2'd3;

   typedef struct packed {
      logic [15:0] lim;
      logic [7:0]  slots;
      logic        gate;
      logic [15:0] exp_cnt;
      logic        exp_mc;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{16'd10, 8'd5,  1'b1, 16'd5, 1'b0},
      '{16'd10, 8'd10, 1'b1, 16'd0, 1'b1},
      '{16'd10, 8'd13, 1'b1, 16'd3, 1'b1},
      '{16'd3,  8'd7,  1'b1, 16'd1, 1'b1},
      '{16'd1,  8'd9,  1'b1, 16'd0, 1'b1},
      '{16'd7,  8'd6,  1'b1, 16'd6, 1'b0},
      '{16'd5,  8'd8,  1'b0, 16'd0, 1'b0},
      '{16'd2,  8'd4,  1'b0, 16'd0, 1'b0}
   };

   always @(negedge clk) begin
      if (mon_on) begin
         if (!tmr_out) low_cnt++;
         if (irq_req) irq_cnt++;
         if (irq_req && tmr_out) irq_mis++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int got, input int lo, input int hi);
      tests++;
      if (got < lo || got > hi) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d..%0d", tag, got, lo, hi);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   // enable commit and disable commit are exactly 4*n edges apart
   task automatic run_slots(input int n, input logic [15:0] base);
      wr(AD_CTL, base | 16'h8000);
      repeat (4 * n - 3) @(negedge clk);
      wr(AD_CTL, base | 16'h0020);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      int lat;

      repeat (3) @(negedge clk);
      chk("R6 reset tmr_out", tmr_out, 1'b1);
      chk("R10 reset irq", irq_req, 1'b0);
      chk("R9 reset ready", bus_ready, 1'b0);
      rst_n = 1'b1;
      rd(AD_CTL, d); chk("R6 reset ctl", d, 16'h0000);
      rd(AD_CNT, d); chk("R1 reset count", d, 16'h0000);

      // R1 readback and R9 handshake timing
      wr(AD_LA, 16'h1234);
      wr(AD_LB, 16'hBEEF);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AD_LA;
      #1 chk("R9 ready low first cycle", bus_ready, 1'b0);
      @(negedge clk);
      chk("R9 ready high second cycle", bus_ready, 1'b1);
      chk("R1 limit A readback", bus_rdata, 16'h1234);
      @(negedge clk);
      bus_sel = 1'b0;
      #1 chk("R9 ready drops after access", bus_ready, 1'b0);
      rd(AD_LB, d); chk("R1 limit B readback", d, 16'hBEEF);

      // R5 R12 R8 R2: table walk, internal source, continuous
      foreach (VECS[i]) begin
         tmr_in = VECS[i].gate;
         wr(AD_CNT, 16'h0000);
         wr(AD_LA, VECS[i].lim);
         wr(AD_CTL, 16'h4001);
         run_slots(int'(VECS[i].slots), 16'h4001);
         rd(AD_CNT, d);
         chk($sformatf("R5 R12 R2 vec%0d count", i), d, VECS[i].exp_cnt);
         rd(AD_CTL, d);
         chk($sformatf("R8 vec%0d flag", i), d[5], VECS[i].exp_mc);
      end

      // R2: limit 0 means full range
      tmr_in = 1'b1;
      wr(AD_CNT, 16'hFFFE);
      wr(AD_LA, 16'h0000);
      wr(AD_CTL, 16'h4001);
      run_slots(3, 16'h4001);
      rd(AD_CNT, d); chk("R2 limit zero wraps", d, 16'h0001);
      rd(AD_CTL, d); chk("R2 limit zero terminal", d[5], 1'b1);

      // R8: writing 1 keeps the flag, writing 0 clears it
      wr(AD_CTL, 16'h0021);
      rd(AD_CTL, d); chk("R8 write one keeps flag", d[5], 1'b1);
      wr(AD_CTL, 16'h0001);
      rd(AD_CTL, d); chk("R8 write zero clears flag", d[5], 1'b0);

      // R1: count write while running
      wr(AD_LA, 16'hFFFF);
      wr(AD_CNT, 16'h0000);
      wr(AD_CTL, 16'hC001);
      wr(AD_CNT, 16'h4000);
      wr(AD_CTL, 16'h4001);
      rd(AD_CNT, d); chk_rng("R1 count write while running", int'(d), 16'h4000, 16'h4001);

      // R6: layout and the enable-write strobe
      tmr_in = 1'b0;
      repeat (4) @(negedge clk);
      wr(AD_CTL, 16'hFFFF);
      rd(AD_CTL, d); chk("R6 all-ones write", d, 16'hA01F);
      wr(AD_CTL, 16'h8000);
      rd(AD_CTL, d); chk("R6 enable held without strobe", d, 16'h8000);
      wr(AD_CTL, 16'h4000);
      rd(AD_CTL, d); chk("R6 enable cleared with strobe", d, 16'h0000);

      // R7 R3 R10: halt at terminal count with interrupt
      tmr_in = 1'b1;
      wr(AD_CNT, 16'h0000);
      wr(AD_LA, 16'd4);
      low_cnt = 0; irq_cnt = 0; irq_mis = 0; mon_on = 1'b1;
      wr(AD_CTL, 16'hE000);
      repeat (40) @(negedge clk);
      mon_on = 1'b0;
      rd(AD_CTL, d); chk("R7 halted, flag set", d, 16'h2020);
      rd(AD_CNT, d); chk("R7 count stays zero", d, 16'h0000);
      chk("R3 one low clock", low_cnt, 1);
      chk("R10 one irq pulse", irq_cnt, 1);
      chk("R10 irq with low output", irq_mis, 0);

      // R7 R3 R10: continuous, interrupt on, then off
      wr(AD_LA, 16'd2);
      wr(AD_CNT, 16'h0000);
      low_cnt = 0; irq_cnt = 0; irq_mis = 0; mon_on = 1'b1;
      run_slots(6, 16'h6001);
      repeat (3) @(negedge clk);
      mon_on = 1'b0;
      chk("R7 R3 continuous low pulses", low_cnt, 3);
      chk("R10 irq pulses", irq_cnt, 3);
      chk("R10 irq aligned", irq_mis, 0);
      wr(AD_CNT, 16'h0000);
      low_cnt = 0; irq_cnt = 0; mon_on = 1'b1;
      run_slots(6, 16'h4001);
      repeat (3) @(negedge clk);
      mon_on = 1'b0;
      chk("R3 low pulses without interrupt", low_cnt, 3);
      chk("R10 no irq when disabled", irq_cnt, 0);

      // R4: alternate limits
      wr(AD_CNT, 16'h0000);
      wr(AD_LA, 16'd3);
      wr(AD_LB, 16'd2);
      wr(AD_CTL, 16'h4003);
      chk("R4 output high on A", tmr_out, 1'b1);
      run_slots(3, 16'h4003);
      chk("R4 output low on B", tmr_out, 1'b0);
      rd(AD_CTL, d); chk("R4 flag shows B", d[12], 1'b1);
      run_slots(2, 16'h4003);
      chk("R4 back to A", tmr_out, 1'b1);
      rd(AD_CTL, d); chk("R4 flag shows A", d[12], 1'b0);
      run_slots(1, 16'h4003);
      rd(AD_CNT, d); chk("R4 counting on A", d, 16'h0001);

      // R11: external edges
      tmr_in = 1'b0;
      wr(AD_CNT, 16'h0000);
      wr(AD_LA, 16'd1000);
      wr(AD_CTL, 16'hC009);
      for (int k = 0; k < 5; k++) begin
         tmr_in = 1'b1; repeat (4) @(negedge clk);
         tmr_in = 1'b0; repeat (4) @(negedge clk);
      end
      repeat (10) @(negedge clk);
      wr(AD_CTL, 16'h4029);
      rd(AD_CNT, d); chk("R11 five edges counted", d, 16'd5);

      // R11: pin to output latency
      wr(AD_CNT, 16'h0000);
      wr(AD_LA, 16'd1);
      wr(AD_CTL, 16'hC009);
      for (int off = 0; off < 4; off++) begin
         repeat (off + 8) @(negedge clk);
         tmr_in = 1'b1;
         lat = 0;
         do begin
            @(negedge clk);
            lat++;
         end while (tmr_out && lat < 20);
         chk_rng($sformatf("R11 latency offset %0d", off), lat, 3, 6);
         tmr_in = 1'b0;
      end
      wr(AD_CTL, 16'h4029);

      // R13: retrigger mode
      tmr_in = 1'b0;
      wr(AD_LA, 16'd1000);
      wr(AD_CNT, 16'd50);
      wr(AD_CTL, 16'h4011);
      run_slots(10, 16'h4011);
      rd(AD_CNT, d); chk("R13 counts without trigger", d, 16'd60);
      wr(AD_CNT, 16'd50);
      wr(AD_CTL, 16'hC011);
      repeat (20) @(negedge clk);
      tmr_in = 1'b1;
      repeat (20) @(negedge clk);
      wr(AD_CTL, 16'h4031);
      rd(AD_CNT, d); chk_rng("R13 edge restarts count", int'(d), 1, 10);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule